// File: doc/BRIEF.md
# Fractional Oversampling Rate Generator

This block turns a fast reference clock into the two clock-enable pulses that one serial channel needs. One is a sample tick at the oversampling rate, and the other is a bit tick once per serial bit. Software loads a 16-bit integer divisor, one byte at a time, and a 4-bit fraction in sixteenths. It also sets a mode byte that selects an optional divide-by-four prescaler and an oversampling ratio of 16, 8 or 4.

The effective division is the integer divisor plus the fraction over sixteen. A 4-bit phase accumulator produces it by adding the fraction at every sample tick. Each carry out of the accumulator lengthens that sample period by one prescaled cycle, so any sixteen consecutive sample periods contain exactly as many stretched periods as the fraction's value.

Any register write restarts the prescaler, the divide counter, the accumulator and the oversample counter, so the tick stream after a reprogram is deterministic. A divisor of zero halts both ticks. With a 125 MHz reference, 4X oversampling and a divisor of one, the bit tick runs at 31.25 MHz. That is the fastest rate the block serves.

Top module: `frac_baud_gen`

## Requirements
- R1: A write (`wr_en` high at a rising edge) stores `wr_data` into the register that `wr_addr` selects. The registers are: 0 for the divisor low byte, 1 for the divisor high byte, 2 for the fraction in `wr_data[3:0]`, and 3 for the mode, where bit0 is the prescaler enable, bit1 selects 8X and bit2 selects 4X. A write to one byte leaves the other divisor byte unchanged.
- R2: After reset, all registers are zero and neither tick pulses.
- R3: While the integer divisor is zero, `sample_tick` and `bit_tick` stay low.
- R4: Without prescaling, with divisor D ≥ 1 and fraction F, the sixteen sample ticks that follow a write take exactly 16·D+F clock cycles in total. Each individual gap is D or D+1 cycles, and exactly F of the gaps are D+1.
- R5: With the prescaler enabled, every count takes four clock cycles, so R4's totals and gaps are multiplied by four.
- R6: The oversampling ratio is 4 when mode bit2 is set (it wins over bit1), 8 when only bit1 is set, and 16 otherwise.
- R7: `bit_tick` pulses only together with `sample_tick`, on every ratio-th sample tick counted from the last write.
- R8: Any write restarts the timing. The first sample tick comes D cycles after the write edge (4·D with the prescaler), and the fraction's first stretch is never on that first period.
- R9: With 4X, D=1, F=0 and no prescaler, `bit_tick` pulses every 4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-rate enable |

## Verification
The bench goes after the fraction distribution by timing sixteen sample ticks per setting and checking the total as well as the shortest and longest gap. An accumulator that drops its carry, or stretches by the wrong amount, shows up as a wrong total or a gap outside D..D+1. It also checks the 4X-over-8X priority, the prescaler multiplier and the bit-tick count per window; a swapped ratio decode gives the wrong number of bit ticks. A single-byte write, a zero divisor and a mid-run reset are checked through the tick outputs. A design that merged the bytes wrongly would show a wrong first-tick time, and one that kept counting at zero would still emit ticks.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int PRESCALE = 4,
  parameter int FRAC_W   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       sample_tick,
  output logic       bit_tick
);
  localparam int DIV_W = 16;
  localparam int PC_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SC_W  = 4;

  logic [7:0]        div_lo, div_hi;
  logic [FRAC_W-1:0] frac;
  logic              presc_on, x8, x4;
  logic [PC_W-1:0]   pc;
  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [SC_W-1:0]   scnt;

  wire [DIV_W-1:0]  divisor = {div_hi, div_lo};
  wire              run     = (divisor != '0);
  wire [FRAC_W:0]   acc_sum = {1'b0, acc} + {1'b0, frac};
  wire              stretch = acc_sum[FRAC_W];
  wire [DIV_W:0]    last    = {1'b0, divisor} - {{DIV_W{1'b0}}, 1'b1} + {{DIV_W{1'b0}}, stretch};
  wire              pen     = presc_on ? (pc == PC_W'(PRESCALE - 1)) : 1'b1;
  wire [SC_W-1:0]   osr_m1  = x4 ? 4'd3 : (x8 ? 4'd7 : 4'd15);

  assign sample_tick = run & pen & ({1'b0, cnt} == last);
  assign bit_tick    = sample_tick & (scnt == osr_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo   <= '0;
      div_hi   <= '0;
      frac     <= '0;
      presc_on <= 1'b0;
      x8       <= 1'b0;
      x4       <= 1'b0;
      pc       <= '0;
      cnt      <= '0;
      acc      <= '0;
      scnt     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: div_lo <= wr_data;
        2'd1: div_hi <= wr_data;
        2'd2: frac   <= wr_data[FRAC_W-1:0];
        default: begin
          presc_on <= wr_data[0];
          x8       <= wr_data[1];
          x4       <= wr_data[2];
        end
      endcase
      pc   <= '0;
      cnt  <= '0;
      acc  <= '0;
      scnt <= '0;
    end else begin
      pc <= (pc == PC_W'(PRESCALE - 1)) ? '0 : pc + 1'b1;
      if (run && pen) begin
        if (sample_tick) begin
          cnt  <= '0;
          acc  <= acc_sum[FRAC_W-1:0];
          scnt <= bit_tick ? '0 : scnt + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        sample_tick,
  input logic        bit_tick,
  input logic [15:0] divisor,
  input logic        presc_on,
  input logic        x8,
  input logic        x4
);
  logic [3:0] sc;
  wire  [3:0] osr_m1 = x4 ? 4'd3 : (x8 ? 4'd7 : 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sc <= '0;
    else if (wr_en)       sc <= '0;
    else if (sample_tick) sc <= (sc == osr_m1) ? 4'd0 : sc + 4'd1;
  end

  AST_IDLE_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 16'd0) |-> !sample_tick && !bit_tick); // R3
  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R7
  AST_BIT_EVERY_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !wr_en) |-> (bit_tick == (sc == osr_m1))); // R6
  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_on && sample_tick && !wr_en) |=> !sample_tick); // R5
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !wr_en && divisor > 16'd1) |=> !sample_tick); // R4
endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .sample_tick(sample_tick), .bit_tick(bit_tick),
  .divisor(divisor), .presc_on(presc_on), .x8(x8), .x4(x4)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sample_tick, bit_tick;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick));

  // {divisor[15:0], frac[3:0], mode[2:0], expected bit ticks per 16 samples[4:0]}
  localparam logic [27:0] VEC [6] = '{
    {16'd1,   4'd0,  3'b000, 5'd1},
    {16'd3,   4'd5,  3'b010, 5'd2},
    {16'd2,   4'd15, 3'b100, 5'd4},
    {16'd1,   4'd8,  3'b001, 5'd1},
    {16'd5,   4'd1,  3'b111, 5'd4},
    {16'd258, 4'd0,  3'b010, 5'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] d, input logic [3:0] f, input logic [2:0] m);
    wr(2'd1, d[15:8]);
    wr(2'd2, {4'd0, f});
    wr(2'd3, {5'd0, m});
    wr(2'd0, d[7:0]);
  endtask

  // Called at the negedge right after the last write: that cycle is c=1.
  task automatic measure(output int total, output int bits, output int first,
                         output int gmin, output int gmax);
    int ticks = 0, prev = 0;
    total = 0; bits = 0; first = 0; gmin = 1 << 30; gmax = 0;
    for (int c = 1; c <= 40000 && ticks < 16; c++) begin
      if (sample_tick) begin
        ticks++;
        if (ticks == 1) first = c;
        if (c - prev < gmin) gmin = c - prev;
        if (c - prev > gmax) gmax = c - prev;
        prev = c;
        total = c;
      end
      if (bit_tick) bits++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    int tot, bits, first, gmin, gmax, p, d, f, btot, last_b;
    #12 rst_n = 1'b1;
    quiet(100, "R2 no ticks after reset");

    foreach (VEC[i]) begin
      d = int'(VEC[i][27:12]);
      f = int'(VEC[i][11:8]);
      p = VEC[i][5] ? 4 : 1;
      cfg(VEC[i][27:12], VEC[i][11:8], VEC[i][7:5]);
      measure(tot, bits, first, gmin, gmax);
      check(tot == p * (16 * d + f), VEC[i][5] ? "R5 prescaled total" : "R4 total", tot, p * (16 * d + f));
      check(bits == int'(VEC[i][4:0]), "R6 R7 bit ticks per window", bits, int'(VEC[i][4:0]));
      check(first == p * d, "R8 first tick after write", first, p * d);
      check(gmin == p * d, "R4 shortest gap", gmin, p * d);
      check(gmax == p * (d + (f != 0 ? 1 : 0)), "R4 longest gap", gmax, p * (d + (f != 0 ? 1 : 0)));
    end

    wr(2'd0, 8'd4);
    measure(tot, bits, first, gmin, gmax);
    check(first == 260, "R1 low byte write keeps high byte", first, 260);

    cfg(16'd1, 4'd0, 3'b100);
    btot = 0; last_b = 0;
    for (int c = 1; c <= 40; c++) begin
      if (bit_tick) begin
        if (last_b != 0) check(c - last_b == 4, "R9 bit tick every 4 cycles", c - last_b, 4);
        btot++;
        last_b = c;
      end
      @(negedge clk);
    end
    check(btot == 10, "R9 bit tick count", btot, 10);

    wr(2'd0, 8'd0);
    quiet(300, "R3 zero divisor halts ticks");

    cfg(16'd2, 4'd3, 3'b000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    quiet(200, "R2 reset clears divisor");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule